// File: doc/BRIEF.md
# Bus master privilege control unit

This unit gives each of four bus masters a privilege bit and uses it to shape the user/supervisor attribute of that master's accesses. A master whose bit is clear has every access demoted to user mode, whatever attribute it drives. A master whose bit is set has its own attribute passed through unchanged. Master 0 is the processor core. Its bit is always 1, so the core is always trusted.

The same unit holds a bank of fourteen 4-bit access-control slots that belong to peripherals. Here they are only stored and read back, and no enforcement is applied to them. All control registers sit behind a simple register-bus slave port. Any master may read them. Only a master whose privilege bit is currently set may write them. A write from any other master ends with an error response and changes nothing.

Top module: `masterPrivUnit`

## Requirements
- R1: After reset, the word at offset 0x020 reads 0x03000000: the privilege field is in bits 27:24 and has reset value 4'b0011. The words at 0x024, 0x028, 0x02C and 0x030 read 0.
- R2: When the privilege bit of master n is 0, `effSuper[n]` is 0 (user mode), whatever `userSuper[n]` is. The value 1 means supervisor.
- R3: When the privilege bit of master n is 1, `effSuper[n]` equals `userSuper[n]`.
- R4: A write to a defined register offset (0x020 to 0x030) from a master whose privilege bit is 0 raises `err`, and no register changes. `masterId` is binary, so master n is ID n.
- R5: The privilege bit of master 0 always reads 1. A write of 0 to bit 24 of offset 0x020 is ignored.
- R6: The trust check uses the privilege value from before the current write. A trusted master may clear its own bit without an error. Its next write then fails.
- R7: Reserved bits read as 0 and ignore writes. At 0x020 these are bits 31:28 and 23:0. At 0x024 to 0x02C they are bits 15:0. At 0x030 they are bits 23:0.
- R8: Reads from any master never raise `err`. A read of an undefined offset, such as 0x034, returns 0. A write to an undefined offset raises no error.
- R9: `err` is asserted only in a cycle where `wrEn` is high, and lasts for that one cycle.
- R10: Slot k sits at offset 0x024+4*(k/4), in bits (31-4*(k%4)) down to (28-4*(k%4)). Slots 12 and 13 occupy bits 31:24 of 0x030. A write replaces every slot of the addressed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register byte offset |
| wrData | input | 32 | Write data |
| wrEn | input | 1 | Write strobe, one cycle per write |
| rdEn | input | 1 | Read strobe; rdData is valid in the same cycle |
| masterId | input | 2 | ID of the master making the register access |
| rdData | output | 32 | Read data, 0 when no read is made |
| err | output | 1 | Error response for a rejected write, in the same cycle |
| userSuper | input | 4 | Attribute each master drives, 1 = supervisor |
| effSuper | output | 4 | Effective attribute for each master |

## Verification
The bench builds the unit with the default values: four masters, fourteen slots, the privilege word at 0x020 and the slot words from 0x024. These values cover every slot word, including the partly filled word at 0x030, and every master ID. The IDs include an ID that is trusted at reset, an ID that is untrusted at reset, and the always-trusted core. The bench has a trusted master give up its own trust, and it checks that the write which does so succeeds while the next write from that master fails.

// File: rtl/mpuPkg.sv
package mpuPkg;
  localparam int NUM_MASTERS = 4;
  localparam int MID_W = $clog2(NUM_MASTERS);
  localparam int NUM_ACC = 14;
  localparam int SLOT_W = 4;
  localparam int SLOTS_PER_WORD = 4;
  localparam int ACC_WORDS = (NUM_ACC + SLOTS_PER_WORD - 1) / SLOTS_PER_WORD;
  localparam int DATA_W = 32;
  localparam int PRIV_LSB = 24;
  localparam logic [NUM_MASTERS-1:0] PRIV_RESET = 4'b0011;

  typedef struct packed {
    logic                 privWe;
    logic [ACC_WORDS-1:0] accWe;
    logic                 rdPriv;
    logic [ACC_WORDS-1:0] rdAcc;
    logic                 err;
  } ctrlStrb_t;
endpackage

// File: rtl/mpuCtrl.sv
module mpuCtrl
  import mpuPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PRIV_OFF = 32,
  parameter int ACC_OFF = 36
) (
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   wrEn,
  input  logic                   rdEn,
  input  logic [MID_W-1:0]       masterId,
  input  logic [NUM_MASTERS-1:0] privField,
  output ctrlStrb_t              strb
);
  logic isPriv;
  logic [ACC_WORDS-1:0] accHit;
  logic defined;
  logic trusted;

  assign isPriv = (addr == ADDR_W'(PRIV_OFF));

  for (genvar w = 0; w < ACC_WORDS; w++) begin : g_hit
    assign accHit[w] = (addr == ADDR_W'(ACC_OFF + 4 * w));
  end

  assign defined = isPriv | (|accHit);
  assign trusted = privField[masterId];

  always_comb begin
    strb.privWe = wrEn & trusted & isPriv;
    strb.accWe  = (wrEn & trusted) ? accHit : '0;
    strb.rdPriv = rdEn & isPriv;
    strb.rdAcc  = rdEn ? accHit : '0;
    strb.err    = wrEn & defined & ~trusted;
  end
endmodule

// File: rtl/mpuData.sv
module mpuData
  import mpuPkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrb_t              strb,
  input  logic [DATA_W-1:0]      wrData,
  input  logic [NUM_MASTERS-1:0] userSuper,
  output logic [NUM_MASTERS-1:0] privField,
  output logic [NUM_MASTERS-1:0] effSuper,
  output logic [DATA_W-1:0]      rdData
);
  localparam int TOP_SLOT_LSB = DATA_W - SLOT_W;

  logic [NUM_MASTERS-1:0] privQ;
  logic [SLOT_W-1:0] accQ [NUM_ACC];
  logic unusedWr;

  assign unusedWr = ^wrData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) privQ <= PRIV_RESET;
    else if (strb.privWe)
      privQ <= wrData[PRIV_LSB +: NUM_MASTERS] | NUM_MASTERS'(1);
  end

  for (genvar k = 0; k < NUM_ACC; k++) begin : g_slot
    localparam int WORD = k / SLOTS_PER_WORD;
    localparam int LSB = TOP_SLOT_LSB - SLOT_W * (k % SLOTS_PER_WORD);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) accQ[k] <= '0;
      else if (strb.accWe[WORD]) accQ[k] <= wrData[LSB +: SLOT_W];
    end
  end

  always_comb begin
    rdData = '0;
    if (strb.rdPriv) rdData[PRIV_LSB +: NUM_MASTERS] = privQ;
    for (int k = 0; k < NUM_ACC; k++) begin
      if (strb.rdAcc[k / SLOTS_PER_WORD])
        rdData[TOP_SLOT_LSB - SLOT_W * (k % SLOTS_PER_WORD) +: SLOT_W] = accQ[k];
    end
  end

  assign privField = privQ;
  assign effSuper = userSuper & privQ;
endmodule

// File: rtl/masterPrivUnit.sv
module masterPrivUnit
  import mpuPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PRIV_OFF = 32,
  parameter int ACC_OFF = 36
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wrData,
  input  logic                   wrEn,
  input  logic                   rdEn,
  input  logic [MID_W-1:0]       masterId,
  output logic [DATA_W-1:0]      rdData,
  output logic                   err,
  input  logic [NUM_MASTERS-1:0] userSuper,
  output logic [NUM_MASTERS-1:0] effSuper
);
  ctrlStrb_t strb;
  logic [NUM_MASTERS-1:0] privField;

  mpuCtrl #(.ADDR_W(ADDR_W), .PRIV_OFF(PRIV_OFF), .ACC_OFF(ACC_OFF)) u_ctrl (
    .addr(addr), .wrEn(wrEn), .rdEn(rdEn), .masterId(masterId),
    .privField(privField), .strb(strb)
  );

  mpuData u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .userSuper(userSuper), .privField(privField),
    .effSuper(effSuper), .rdData(rdData)
  );

  assign err = strb.err;
endmodule

// File: rtl/mpuChecker.sv
module mpuChecker
  import mpuPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PRIV_OFF = 32
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [ADDR_W-1:0]      addr,
  input logic                   wrEn,
  input logic [MID_W-1:0]       masterId,
  input logic                   err,
  input logic [NUM_MASTERS-1:0] userSuper,
  input logic [NUM_MASTERS-1:0] effSuper,
  input logic [NUM_MASTERS-1:0] privField
);
  // R2/R3: never raises a master above what it drives
  p_no_raise_r3: assert property (@(posedge clk) disable iff (!rstN)
    (effSuper & ~userSuper) == '0);

  // R5: core attribute always passes through
  p_core_pass_r5: assert property (@(posedge clk) disable iff (!rstN)
    effSuper[0] == userSuper[0]);

  // R5: core privilege bit stays set
  p_core_bit_r5: assert property (@(posedge clk) disable iff (!rstN)
    privField[0]);

  // R4: untrusted write to the privilege word is rejected
  p_untrusted_err_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(PRIV_OFF) && !privField[masterId]) |-> err);

  // R4: rejected write leaves privilege unchanged
  p_err_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    err |=> $stable(privField));

  // R9: error only alongside a write strobe
  p_err_with_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    err |-> wrEn);
endmodule

bind masterPrivUnit mpuChecker #(.ADDR_W(ADDR_W), .PRIV_OFF(PRIV_OFF)) u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .masterId(masterId),
  .err(err), .userSuper(userSuper), .effSuper(effSuper), .privField(privField)
);

// File: tb/tb_masterPrivUnit.sv
module tb_masterPrivUnit;
  logic clk = 0;
  logic rstN = 0;
  logic [7:0] addr = 0;
  logic [31:0] wrData = 0;
  logic wrEn = 0, rdEn = 0;
  logic [1:0] masterId = 0;
  logic [31:0] rdData;
  logic err;
  logic [3:0] userSuper = 0;
  logic [3:0] effSuper;

  masterPrivUnit dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn),
    .rdEn(rdEn), .masterId(masterId), .rdData(rdData), .err(err),
    .userSuper(userSuper), .effSuper(effSuper)
  );

  always #5 clk = ~clk;

  typedef struct {
    string tag;
    logic chkRd;
    logic [31:0] expRd;
    logic expErr;
    logic [3:0] expEff;
  } item_t;

  item_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  logic [3:0] privM = 4'b0011;
  logic [3:0] accM [14];

  function automatic logic [31:0] readModel(input logic [7:0] a);
    logic [31:0] v = 0;
    if (a == 8'h20) v[27:24] = privM;
    for (int k = 0; k < 14; k++)
      if (a == 8'(8'h24 + 4 * (k / 4))) v[31 - 4 * (k % 4) -: 4] = accM[k];
    return v;
  endfunction

  function automatic logic isDefined(input logic [7:0] a);
    return a == 8'h20 || a == 8'h24 || a == 8'h28 || a == 8'h2C || a == 8'h30;
  endfunction

  task automatic tx(input string tag, input logic w, input logic r,
                    input logic [7:0] a, input logic [31:0] d,
                    input logic [1:0] mid, input logic [3:0] us);
    item_t it;
    logic trusted;
    @(posedge clk); #1;
    wrEn = w; rdEn = r; addr = a; wrData = d; masterId = mid; userSuper = us;
    trusted = privM[mid];
    it.tag = tag;
    it.chkRd = 1;
    it.expRd = r ? readModel(a) : 32'h0;
    it.expErr = w && isDefined(a) && !trusted;
    it.expEff = us & privM;
    q.push_back(it);
    if (w && trusted) begin
      if (a == 8'h20) privM = d[27:24] | 4'b0001;
      for (int k = 0; k < 14; k++)
        if (a == 8'(8'h24 + 4 * (k / 4))) accM[k] = d[31 - 4 * (k % 4) -: 4];
    end
  endtask

  task automatic idle(input string tag, input logic [3:0] us);
    tx(tag, 0, 0, 8'h00, 32'h0, 2'd0, us);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (rdData !== it.expRd || err !== it.expErr || effSuper !== it.expEff) begin
        fails++;
        $display("FAIL %s: rd=%h err=%b eff=%b expected rd=%h err=%b eff=%b",
                 it.tag, rdData, err, effSuper, it.expRd, it.expErr, it.expEff);
      end
    end
  end

  initial begin
    for (int k = 0; k < 14; k++) accM[k] = 4'h0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1 reset values, read by untrusted master (R8)
    tx("R1 priv reset", 0, 1, 8'h20, 0, 2'd2, 4'hF);
    tx("R1 acc0 reset", 0, 1, 8'h24, 0, 2'd3, 4'h0);
    tx("R1 acc3 reset", 0, 1, 8'h30, 0, 2'd2, 4'h0);
    // R2 R3 attribute shaping
    tx("R2 R3 eff all", 0, 0, 8'h00, 0, 2'd0, 4'hF);
    tx("R2 R3 eff pat", 0, 0, 8'h00, 0, 2'd0, 4'b0110);
    // R4 untrusted writes rejected
    tx("R4 untrusted priv wr", 1, 0, 8'h20, 32'h0F000000, 2'd2, 4'hF);
    idle("R9 err drops", 4'hF);
    tx("R4 priv unchanged", 0, 1, 8'h20, 0, 2'd0, 4'hF);
    tx("R4 untrusted acc wr", 1, 0, 8'h28, 32'hFFFF0000, 2'd3, 4'h0);
    tx("R4 acc unchanged", 0, 1, 8'h28, 0, 2'd0, 4'h0);
    // R5 R7 core writes, bit0 forced, reserved ignored
    tx("R5 core clear bit0", 1, 0, 8'h20, 32'hFE000000, 2'd0, 4'h0);
    tx("R5 R7 priv readback", 0, 1, 8'h20, 0, 2'd1, 4'hF);
    tx("R5 clear all", 1, 0, 8'h20, 32'h00000000, 2'd0, 4'h0);
    tx("R5 bit0 kept", 0, 1, 8'h20, 0, 2'd3, 4'hF);
    tx("R2 only core", 0, 0, 8'h00, 0, 2'd0, 4'hF);
    // R10 R7 slot layout
    tx("R10 wr acc0", 1, 0, 8'h24, 32'h1234ABCD, 2'd0, 4'h0);
    tx("R10 wr acc1", 1, 0, 8'h28, 32'h5678FFFF, 2'd0, 4'h0);
    tx("R10 wr acc2", 1, 0, 8'h2C, 32'h9ABC0000, 2'd0, 4'h0);
    tx("R10 wr acc3", 1, 0, 8'h30, 32'hDEF01234, 2'd0, 4'h0);
    tx("R10 R7 rd acc0", 0, 1, 8'h24, 0, 2'd1, 4'h0);
    tx("R10 R7 rd acc1", 0, 1, 8'h28, 0, 2'd1, 4'h0);
    tx("R10 R7 rd acc2", 0, 1, 8'h2C, 0, 2'd1, 4'h0);
    tx("R10 R7 rd acc3", 0, 1, 8'h30, 0, 2'd1, 4'h0);
    // R6 trust from pre-write value
    tx("R6 grant m1", 1, 0, 8'h20, 32'h02000000, 2'd0, 4'h0);
    tx("R6 m1 self clear", 1, 0, 8'h20, 32'h01000000, 2'd1, 4'hF);
    tx("R6 m1 now refused", 1, 0, 8'h20, 32'h0F000000, 2'd1, 4'hF);
    tx("R6 priv after", 0, 1, 8'h20, 0, 2'd2, 4'hF);
    // R8 undefined offsets
    tx("R8 undef read", 0, 1, 8'h34, 0, 2'd2, 4'h0);
    tx("R8 undef untrusted wr", 1, 0, 8'h34, 32'hFFFFFFFF, 2'd2, 4'h0);
    tx("R8 wr then read", 1, 0, 8'h30, 32'h77000000, 2'd3, 4'h0);
    tx("R8 acc3 unchanged", 0, 1, 8'h30, 0, 2'd3, 4'h0);
    idle("R9 idle", 4'h0);
    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule